// File: doc/BRIEF.md
# Phase-Accumulating Sine Synthesizer

This block produces a stream of signed sine samples whose frequency is set by a programmable tuning word. A wide phase register gains the tuning word on every clock, modulo 2^N. Its upper P bits select an entry of a sine table that holds one full period. The table is computed at elaboration. The registered table value is the sample word handed to an external converter.

The output frequency is W·Fclk/2^N. With N = 32 and a 20 MHz clock, this gives a step of well under one hertz. The low N−P phase bits are never discarded between periods, so the block does not act as an integer divider: each period may start at a different table address. A tuning word above the Nyquist bound is limited to that bound. A new word is taken only when the load strobe is high, and the phase carries on from where it was.

Integration is simple. Hold the load strobe for one clock with the desired word, then read `sample_o` on every clock. `wrap_o` marks each phase rollover and can be used to count output periods.

Top module: `dds_sine_gen`

## Requirements
- R1: On every clock after reset, the phase register increases by the active tuning word modulo 2^N (default N = 32).
- R2: The sample equals round((2^(A−1)−1)·sin(2π·k/2^P)), where k is bits [N−1:N−P] of the phase register. Defaults are P = 10 and A = 12, two's complement.
- R3: A phase value reaches `sample_o` two clocks after the edge that produced it: one clock in an address register and one in the sample register.
- R4: A loaded word greater than 2^(N−1)−1 is stored as 2^(N−1)−1.
- R5: The active tuning word changes only on a clock where `tune_load_i` is 1. The phase register is not disturbed by a load: the edge that loads a word still adds the previous word.
- R6: Synchronous reset clears the phase register, the tuning word, the address register, the sample and `wrap_o` to zero.
- R7: With a tuning word of 0, the phase and the sample stay constant, and after reset the sample stays 0.
- R8: `wrap_o` is 1 for exactly the clocks whose phase addition carried out of bit N−1, aligned with the phase update. Over K clocks from phase 0 with word W, it pulses floor(K·W/2^N) times.
- R9: On a rollover the phase keeps its residue (sum − 2^N) rather than restarting at a fixed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tune_word_i | input | N | Requested phase increment |
| tune_load_i | input | 1 | Loads `tune_word_i` (after limiting) on this clock |
| sample_o | output | A | Signed sine sample |
| wrap_o | output | 1 | One-clock pulse on phase rollover |

## Verification
The hardest conditions to reach are the phase rollovers that leave a residue. The top address bits alone cannot reveal them, because a single carry can land on any table entry, and only long runs with a word that does not divide 2^N expose a residue handled wrongly. The stimulus holds such non-divisor words for thousands of clocks and counts the rollover pulses against floor(K·W/2^N). It also compares every sample against a reference phase that the bench keeps itself. A stepping word of 2^(N−P) sweeps every table entry once. Random loads include words beyond the bound and reloads in mid-period, which test the limiting and the continuity of the phase.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Rounded sine code for table index k of 2^p entries, amplitude 2^(a-1)-1.
    function automatic int sine_code(input int k, input int p, input int a);
        real amp;
        real ang;
        real val;
        amp = real'((1 << (a - 1)) - 1);
        ang = 6.283185307179586 * real'(k) / real'(1 << p);
        val = amp * $sin(ang);
        if (val >= 0.0) begin
            return $rtoi(val + 0.5);
        end
        return $rtoi(val - 0.5);
    endfunction

endpackage

// File: rtl/dds_tune_reg.sv
module dds_tune_reg #(
    parameter int N = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] word_i,
    input  logic         load_i,
    output logic [N-1:0] tune_o
);
    localparam logic [N-1:0] W_MAX = {1'b0, {(N-1){1'b1}}};

    logic [N-1:0] tune_q;
    logic [N-1:0] limited;

    always_comb begin
        limited = (word_i > W_MAX) ? W_MAX : word_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tune_q <= '0;
        end else if (load_i) begin
            tune_q <= limited;
        end
    end

    assign tune_o = tune_q;

    // R4
    tune_clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tune_q <= W_MAX);

    // R5
    tune_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(tune_q));

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int N = 32,
    parameter int P = 10
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] tune_i,
    output logic [P-1:0] index_o,
    output logic         wrap_o
);
    logic [N-1:0] acc_q;
    logic         wrap_q;
    logic [N:0]   sum;
    logic         seen_q;

    always_comb begin
        sum = {1'b0, acc_q} + {1'b0, tune_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q  <= '0;
            wrap_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            acc_q  <= sum[N-1:0];
            wrap_q <= sum[N];
            seen_q <= 1'b1;
        end
    end

    assign index_o = acc_q[N-1 -: P];
    assign wrap_o  = wrap_q;

    // R8
    wrap_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && wrap_q) |-> (acc_q < $past(acc_q)));

    // R7
    acc_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_q && tune_i == '0) |=> $stable(acc_q));

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int P = 10,
    parameter int A = 12
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [P-1:0]        index_i,
    output logic signed [A-1:0] sample_o
);
    localparam int DEPTH = 1 << P;

    logic signed [A-1:0] table_w [DEPTH];
    logic [P-1:0]        addr_q;
    logic signed [A-1:0] sample_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = A'(dds_pkg::sine_code(g, P, A));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_q   <= '0;
            sample_q <= '0;
        end else begin
            addr_q   <= index_i;
            sample_q <= table_w[addr_q];
        end
    end

    assign sample_o = sample_q;

    // R3
    rom_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $stable(addr_q) |=> $stable(sample_q));

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
    parameter int N = 32,
    parameter int P = 10,
    parameter int A = 12
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N-1:0]        tune_word_i,
    input  logic                tune_load_i,
    output logic signed [A-1:0] sample_o,
    output logic                wrap_o
);
    logic [N-1:0] tune;
    logic [P-1:0] index;

    dds_tune_reg #(.N(N)) u_tune (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .word_i (tune_word_i),
        .load_i (tune_load_i),
        .tune_o (tune)
    );

    dds_phase_acc #(.N(N), .P(P)) u_acc (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tune_i  (tune),
        .index_o (index),
        .wrap_o  (wrap_o)
    );

    dds_sine_rom #(.P(P), .A(A)) u_rom (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .index_i  (index),
        .sample_o (sample_o)
    );

    // R8
    wrap_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (tune < {1'b0, {(N-1){1'b1}}}) && wrap_o |=> !wrap_o || (tune != '0));

endmodule

// File: tb/test_dds_sine_gen.sv
module test_dds_sine_gen;
    localparam int N = 32;
    localparam int P = 10;
    localparam int A = 12;
    localparam logic [N-1:0] W_MAX = {1'b0, {(N-1){1'b1}}};

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [N-1:0]        tune_word = '0;
    logic                tune_load = 1'b0;
    logic signed [A-1:0] sample;
    logic                wrap;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    dds_sine_gen #(.N(N), .P(P), .A(A)) i_dds_sine_gen (
        .clk_i       (clk),
        .rst_i       (rst),
        .tune_word_i (tune_word),
        .tune_load_i (tune_load),
        .sample_o    (sample),
        .wrap_o      (wrap)
    );

    always #5 clk = ~clk;

    function automatic int sine_ref(input int k);
        real v;
        v = 2047.0 * $sin(6.283185307179586 * real'(k) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    endfunction

    function automatic logic [N-1:0] clamp_ref(input logic [N-1:0] w);
        return (w > W_MAX) ? W_MAX : w;
    endfunction

    // Reference state, advanced on each rising edge from the driven inputs.
    logic [N-1:0] m_acc = '0;
    logic [N-1:0] m_tune = '0;
    logic [P-1:0] m_addr = '0;
    int           m_sample = 0;
    logic         m_wrap = 1'b0;

    always @(posedge clk) begin
        logic [N:0] s;
        cycles++;
        if (rst) begin
            m_acc = '0; m_tune = '0; m_addr = '0; m_sample = 0; m_wrap = 1'b0;
        end else begin
            s = {1'b0, m_acc} + {1'b0, m_tune};
            m_sample = sine_ref(int'(m_addr));
            m_addr = m_acc[N-1 -: P];
            m_wrap = s[N];
            m_acc = s[N-1:0];
            if (tune_load) m_tune = clamp_ref(tune_word);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_cycle();
        check(int'(sample) == m_sample, "R1 R2 R3 R5 R9 sample", int'(sample), m_sample);
        check(wrap == m_wrap, "R8 wrap", int'(wrap), int'(m_wrap));
    endtask

    task automatic step(input logic [N-1:0] w, input bit ld);
        tune_word = w;
        tune_load = ld;
        @(negedge clk);
        cmp_cycle();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tune_load = 1'b0;
        repeat (3) @(negedge clk);
        check(sample == '0 && wrap == 1'b0, "R6 reset", int'(sample), 0);
        rst = 1'b0;
    endtask

    task automatic wrap_count(input logic [N-1:0] w, input int k);
        longint exp_n;
        int got;
        do_reset();
        step(w, 1'b1);
        tune_load = 1'b0;
        got = 0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            cmp_cycle();
            if (wrap) got++;
        end
        exp_n = (longint'(k) * longint'(w)) >>> N;
        check(got == int'(exp_n), "R8 R9 wrap count", got, int'(exp_n));
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R7: zero word after reset keeps the sample at 0
        for (int i = 0; i < 20; i++) begin
            step('0, 1'b0);
            check(sample == '0, "R7 zero word", int'(sample), 0);
        end
        // R2: one address per clock sweeps the whole table
        step(32'h0040_0000, 1'b1);
        for (int i = 0; i < 1100; i++) step('0, 1'b0);
        // R4: words beyond the bound are limited
        step(32'hFFFF_FFFF, 1'b1);
        for (int i = 0; i < 50; i++) step('0, 1'b0);
        step(32'h8000_0000, 1'b1);
        for (int i = 0; i < 50; i++) step('0, 1'b0);
        // R7: freezing the phase mid-period holds the sample
        step('0, 1'b1);
        for (int i = 0; i < 20; i++) step(32'h1234_5678, 1'b0);
        // R8 R9: non-divisor words over long windows
        wrap_count(32'h0400_03E7, 3000);
        wrap_count(32'h0123_4567, 5000);
        wrap_count(W_MAX, 400);
        // R1 R5: random words and random loads
        do_reset();
        for (int i = 0; i < 20000; i++) begin
            step($urandom(), ($urandom() % 16) == 0);
        end
        // R6: reset in mid-run clears everything
        do_reset();
        step('0, 1'b0);
        check(sample == '0, "R6 after reset", int'(sample), 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule